// File: doc/BRIEF.md
# Parallel Flash Programming Controller

This block is a clocked host-side master for an asynchronous byte-wide flash bus. It drives active-low chip-enable, write-enable and output-enable strobes, a 17-bit address and a byte data bus whose drive is split into an output value and an output-enable, with a separate input path. A client issues one request at a time: a plain byte read, a byte program, a whole-chip erase, or the one-time lock of the protected boot region. For every operation that writes, the controller emits the multi-write unlock sequence with write-enable-controlled timing. It then finds out when the device has finished by re-reading a location and watching data bit 7, and it stops with an error flag if that takes too long.

All bus timing is set in nanoseconds through parameters and turned into whole clock cycles, rounding up against the clock-period parameter. Program, erase and lock each have their own cycle limit, because a byte program finishes in tens of microseconds while an erase can take seconds. The data bus is driven only while a write is in progress. It is released one clock before output-enable falls. Chip-enable stays low across each write pulse, so the write-enable edges alone set the capture timing.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After a synchronous reset, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are high, `fl_dq_oe`, `busy` and `done` are low.
- R2: A request (`req` high for a cycle) is taken only while `busy` is low. A request raised while `busy` is high adds no bus write and no extra `done`, and the operation in progress keeps its address and data.
- R3: Every write strobe holds `fl_we_n` low for at least ceil(T_WP_NS/CLK_NS) cycles. Consecutive strobes of one operation are separated by at least ceil(T_WPH_NS/CLK_NS) high cycles. While `fl_we_n` is low, `fl_ce_n` is low and `fl_oe_n` is high.
- R4: The address is constant from the falling to the rising `fl_we_n` edge, and that span covers ceil(T_AH_NS/CLK_NS) cycles. The driven data is constant for at least ceil(T_DS_NS/CLK_NS) cycles ending at the rising edge.
- R5: A program (`req_op` = 1) writes, in this order, (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0xA0), (target address, data byte).
- R6: An erase (`req_op` = 2) writes, in this order, (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0x80), (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0x10).
- R7: A boot lock (`req_op` = 3) writes the R6 sequence with a final byte of 0x40, makes no read, and raises `done` with `err` low exactly ceil(T_WPH_NS/CLK_NS) + LOCK_WAIT_CYC cycles after the final `fl_we_n` rise.
- R8: `fl_dq_oe` is high only during write steps. It is low while `fl_oe_n` is low and in the cycle before `fl_oe_n` falls.
- R9: A read (`req_op` = 0) makes no write. It holds `fl_ce_n` and `fl_oe_n` low with `fl_we_n` high for exactly ceil(T_ACC_NS/CLK_NS) cycles, and presents the sampled byte on `rdata` with `done` on the edge 1 + ceil(T_ACC_NS/CLK_NS) after the accepting edge.
- R10: After a program, the controller re-reads the target address until bit 7 equals bit 7 of the written byte. It then raises `done` with `err` low and `rdata` holding the byte last read.
- R11: After an erase, the controller re-reads address 0 until bit 7 reads 1, then raises `done` with `err` low.
- R12: If a failing poll ends once PROG_TMO_CYC (program) or ERASE_TMO_CYC (erase) polling cycles have passed, `done` rises with `err` high. This is never earlier than that many cycles after the final `fl_we_n` rise.
- R13: `done` is a one-cycle pulse. `busy` is high from the cycle after acceptance up to the `done` cycle, where it is already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 boot lock |
| req_addr | input | 17 | Target address for read or program |
| req_data | input | 8 | Byte to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Polling timed out (valid with done, held until next request) |
| rdata | output | 8 | Last byte read from the device |
| fl_addr | output | 17 | Flash address |
| fl_dq_o | output | 8 | Flash data out |
| fl_dq_oe | output | 1 | Flash data drive enable |
| fl_dq_i | input | 8 | Flash data in |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
All strobes are registered, so each bus change shows up one edge after the state that asks for it. The bench samples on the falling clock edge and measures strobe widths by counting those samples. A plain read finishes exactly 1 + ceil(T_ACC_NS/CLK_NS) edges after the accepting edge. A lock finishes exactly ceil(T_WPH_NS/CLK_NS) + LOCK_WAIT_CYC edges after the last write-enable rise. The bench checks both counts against its own cycle counter. For program and erase, the finish time depends on how long the bench's device model stays busy. There the bench checks the result flag, the poll address and a lower bound on the timeout latency, and it waits for `done` within a bounded window.

// File: rtl/fpc_pkg.sv
// Shared types and elaboration-time helpers for the flash programming controller.
// Assumes: op encoding is fixed, because the client drives it as raw bits.
package fpc_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_LOCK  = 2'd3
    } fpc_op_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SET  = 3'd1,
        ST_WLO  = 3'd2,
        ST_WHI  = 3'd3,
        ST_GAP  = 3'd4,
        ST_RD   = 3'd5,
        ST_WAIT = 3'd6
    } fpc_st_e;

    // Convert nanoseconds to whole clock cycles, rounding up, minimum one.
    function automatic int ns2cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpc_cmd_table.sv
// Unlock-sequence table: maps (operation, step) to the bus address and byte
// of each write, and flags the final step.
// Assumes: step stays within the sequence length of the operation
// (4 for program, 6 for erase and lock).
module fpc_cmd_table
    import fpc_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  fpc_op_e              op,
    input  logic [2:0]           step,
    input  logic [ADDR_W-1:0]    tgt_addr,
    input  logic [DATA_W-1:0]    tgt_data,
    output logic [ADDR_W-1:0]    cmd_addr,
    output logic [DATA_W-1:0]    cmd_data,
    output logic                 cmd_last
);
    localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(17'h05555);
    localparam logic [ADDR_W-1:0] KEY_B = ADDR_W'(17'h02AAA);

    // Select the address and byte of the current write step.
    always_comb begin
        cmd_addr = KEY_A;
        cmd_data = DATA_W'(8'hAA);
        cmd_last = 1'b0;
        case (step)
            3'd0: cmd_data = DATA_W'(8'hAA);
            3'd1: begin cmd_addr = KEY_B; cmd_data = DATA_W'(8'h55); end
            3'd2: cmd_data = (op == OP_PROG) ? DATA_W'(8'hA0) : DATA_W'(8'h80);
            3'd3: begin
                if (op == OP_PROG) begin
                    cmd_addr = tgt_addr;
                    cmd_data = tgt_data;
                    cmd_last = 1'b1;
                end else begin
                    cmd_data = DATA_W'(8'hAA);
                end
            end
            3'd4: begin cmd_addr = KEY_B; cmd_data = DATA_W'(8'h55); end
            default: begin
                cmd_data = (op == OP_LOCK) ? DATA_W'(8'h40) : DATA_W'(8'h10);
                cmd_last = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/fpc_window_cnt.sv
// Saturating window counter for the completion phase. It measures how long
// polling (program, erase) or the fixed pause (lock) has lasted, against a
// per-operation cycle limit.
// Assumes: clr and en are never high together; op is constant while en is high.
module fpc_window_cnt
    import fpc_pkg::*;
#(
    parameter int PROG_LIM  = 5000,
    parameter int ERASE_LIM = 1000000000,
    parameter int LOCK_LIM  = 100000000
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clr,
    input  logic    en,
    input  fpc_op_e op,
    output logic    expired
);
    localparam int MAXL = imax(imax(PROG_LIM, ERASE_LIM), LOCK_LIM);
    localparam int W    = $clog2(MAXL + 1);

    logic [W-1:0] cnt;
    logic [W-1:0] lim_m1;

    // Pick the last counted cycle of the window for the current operation.
    always_comb begin
        case (op)
            OP_PROG:  lim_m1 = W'(PROG_LIM - 1);
            OP_ERASE: lim_m1 = W'(ERASE_LIM - 1);
            OP_LOCK:  lim_m1 = W'(LOCK_LIM - 1);
            default:  lim_m1 = '0;
        endcase
    end

    assign expired = (cnt >= lim_m1);

    // Count enabled cycles until the limit is reached, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (en && !expired) cnt <= cnt + 1'b1;
    end

    AST_WINDOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && expired && $stable(op)) |=> expired); // R12
endmodule

// File: rtl/flash_prog_ctrl.sv
// Host-side controller for an asynchronous byte-wide flash bus. It runs the
// read, program, erase and boot-lock operations: timed unlock writes, then
// bit-7 data polling or a fixed pause, then a done pulse with an error flag.
// Assumes: one request at a time (requests while busy are dropped); the timing
// parameters describe the slowest device grade; all strobes come from flops.
module flash_prog_ctrl
    import fpc_pkg::*;
#(
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 8,
    parameter int CLK_NS        = 10,
    parameter int T_WP_NS       = 200,
    parameter int T_WPH_NS      = 200,
    parameter int T_AH_NS       = 100,
    parameter int T_DS_NS       = 100,
    parameter int T_ACC_NS      = 150,
    parameter int PROG_TMO_CYC  = 5000,
    parameter int ERASE_TMO_CYC = 1000000000,
    parameter int LOCK_WAIT_CYC = 100000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_dq_o,
    output logic              fl_dq_oe,
    input  logic [DATA_W-1:0] fl_dq_i,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n
);
    localparam int N_LO  = imax(imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_AH_NS, CLK_NS)),
                                ns2cyc(T_DS_NS, CLK_NS));
    localparam int N_HI  = ns2cyc(T_WPH_NS, CLK_NS);
    localparam int N_ACC = ns2cyc(T_ACC_NS, CLK_NS);
    localparam int TW    = $clog2(imax(imax(N_LO, N_HI), N_ACC) + 1);

    fpc_st_e           st, st_n;
    fpc_op_e           opr;
    logic [ADDR_W-1:0] taddr;
    logic [DATA_W-1:0] tdata;
    logic [2:0]        step;
    logic [TW-1:0]     tmr;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic              cmd_last;
    logic              expired;
    logic              poll_ok;
    logic              phase_end;
    logic              wr_phase;

    fpc_cmd_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tab (
        .op(opr), .step(step), .tgt_addr(taddr), .tgt_data(tdata),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_last(cmd_last)
    );

    fpc_window_cnt #(.PROG_LIM(PROG_TMO_CYC), .ERASE_LIM(ERASE_TMO_CYC),
                     .LOCK_LIM(LOCK_WAIT_CYC)) u_win (
        .clk(clk), .rst_n(rst_n), .clr(st == ST_IDLE),
        .en(st == ST_GAP || st == ST_RD || st == ST_WAIT),
        .op(opr), .expired(expired)
    );

    assign phase_end = (tmr == '0);
    assign wr_phase  = (st == ST_SET) || (st == ST_WLO) || (st == ST_WHI);
    assign poll_ok   = (opr == OP_ERASE) ? fl_dq_i[DATA_W-1]
                                         : (fl_dq_i[DATA_W-1] == tdata[DATA_W-1]);
    assign busy      = (st != ST_IDLE);
    assign fl_addr   = wr_phase ? cmd_addr : ((opr == OP_ERASE) ? '0 : taddr);
    assign fl_dq_o   = cmd_data;

    // Next-state decision for the operation sequencer.
    always_comb begin
        st_n = st;
        case (st)
            ST_IDLE: if (req) st_n = (fpc_op_e'(req_op) == OP_READ) ? ST_GAP : ST_SET;
            ST_SET:  st_n = ST_WLO;
            ST_WLO:  if (phase_end) st_n = ST_WHI;
            ST_WHI:  if (phase_end)
                         st_n = !cmd_last ? ST_SET : ((opr == OP_LOCK) ? ST_WAIT : ST_GAP);
            ST_GAP:  st_n = ST_RD;
            ST_RD:   if (phase_end)
                         st_n = (opr == OP_READ || poll_ok || expired) ? ST_IDLE : ST_GAP;
            ST_WAIT: if (expired) st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
    end

    // State, phase timer, request latch, result capture and registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            opr      <= OP_READ;
            taddr    <= '0;
            tdata    <= '0;
            step     <= '0;
            tmr      <= '0;
            rdata    <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
            fl_ce_n  <= 1'b1;
            fl_we_n  <= 1'b1;
            fl_oe_n  <= 1'b1;
            fl_dq_oe <= 1'b0;
        end else begin
            st       <= st_n;
            done     <= (st != ST_IDLE) && (st_n == ST_IDLE);
            fl_ce_n  <= (st_n == ST_IDLE) || (st_n == ST_WAIT);
            fl_we_n  <= (st_n != ST_WLO);
            fl_oe_n  <= (st_n != ST_RD);
            fl_dq_oe <= (st_n == ST_SET) || (st_n == ST_WLO) || (st_n == ST_WHI);
            if (st_n != st) begin
                case (st_n)
                    ST_WLO:  tmr <= TW'(N_LO - 1);
                    ST_WHI:  tmr <= TW'(N_HI - 1);
                    ST_RD:   tmr <= TW'(N_ACC - 1);
                    default: tmr <= '0;
                endcase
            end else if (!phase_end) begin
                tmr <= tmr - 1'b1;
            end
            if (st == ST_IDLE && req) begin
                opr   <= fpc_op_e'(req_op);
                taddr <= req_addr;
                tdata <= req_data;
                step  <= '0;
                err   <= 1'b0;
            end
            if (st == ST_WHI && phase_end && !cmd_last) step <= step + 1'b1;
            if (st == ST_RD && phase_end) begin
                rdata <= fl_dq_i;
                if (opr != OP_READ && !poll_ok && expired) err <= 1'b1;
            end
        end
    end

    AST_WRITE_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> (!fl_ce_n && fl_oe_n)); // R3
    AST_ADDR_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_o))); // R4
    AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> (!fl_dq_oe && $past(!fl_dq_oe))); // R8
    AST_READ_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> (fl_we_n && !fl_ce_n)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R13
    AST_REQ_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(opr) && $stable(taddr) && $stable(tdata))); // R2
endmodule

// File: tb/sim_flash_prog_ctrl.sv
// Self-checking bench: behavioural flash model with a busy window, strobe
// timing monitors, and sweeps over every operation and several data patterns.
module sim_flash_prog_ctrl;
    localparam int CLK_NS = 10;
    localparam int PTMO   = 200;
    localparam int ETMO   = 400;
    localparam int LWAIT  = 50;
    localparam int N_LO   = (200 + CLK_NS - 1) / CLK_NS;   // 20
    localparam int N_HI   = (200 + CLK_NS - 1) / CLK_NS;   // 20
    localparam int N_DS   = (100 + CLK_NS - 1) / CLK_NS;   // 10
    localparam int N_ACC  = (150 + CLK_NS - 1) / CLK_NS;   // 15

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic        busy, done, err;
    logic [7:0]  rdata;
    logic [16:0] fl_addr;
    logic [7:0]  fl_dq_o, fl_dq_i;
    logic        fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    flash_prog_ctrl #(.CLK_NS(CLK_NS), .PROG_TMO_CYC(PTMO), .ERASE_TMO_CYC(ETMO),
                      .LOCK_WAIT_CYC(LWAIT)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_op(req_op), .req_addr(req_addr),
        .req_data(req_data), .busy(busy), .done(done), .err(err), .rdata(rdata),
        .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i),
        .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] pat(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ {7'b0, a[16]};
    endfunction

    // Flash model state
    int          busy_cnt = 0;
    int          arm_len = 0;
    int          exp_n = 0;
    logic        fin_valid = 1'b0;
    logic [16:0] fin_addr = '0;
    logic [7:0]  fin_data = '0;
    logic [16:0] exp_paddr = '0;

    assign fl_dq_i = (busy_cnt > 0) ? {~fin_data[7], fin_data[6:0]} :
                     (fin_valid && fl_addr == fin_addr) ? fin_data : pat(fl_addr);

    // Monitor state
    int          wr_cnt = 0, rd_cnt = 0, done_cnt = 0;
    int          rise_cyc = 0, done_cyc = 0;
    logic [16:0] wa [8];
    logic [7:0]  wd [8];
    int          lo_run = 0, hi_run = 0, ds_run = 0, oe_run = 0;
    logic        p_we = 1'b1, p_oe = 1'b1, p_dqoe = 1'b0;
    logic [7:0]  p_dq = '0;
    logic [16:0] fall_addr = '0;

    // Bus monitor and busy-window model, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (fl_dq_oe && p_dqoe && fl_dq_o == p_dq) ds_run++;
            else ds_run = fl_dq_oe ? 1 : 0;
            if (!fl_we_n) begin
                if (p_we) begin
                    fall_addr = fl_addr;
                    if (wr_cnt > 0) chk(hi_run >= N_HI, "R3 WE high gap", hi_run, N_HI);
                end
                lo_run++;
                if (fl_addr != fall_addr || fl_ce_n || !fl_oe_n)
                    chk(1'b0, "R4/R3 address or strobes during write", fl_addr, fall_addr);
            end else if (!p_we) begin
                chk(lo_run >= N_LO, "R3 WE low width", lo_run, N_LO);
                chk(ds_run >= N_DS, "R4 data setup", ds_run, N_DS);
                if (wr_cnt < 8) begin wa[wr_cnt] = fall_addr; wd[wr_cnt] = p_dq; end
                wr_cnt++;
                rise_cyc = cyc;
                if (wr_cnt == exp_n) busy_cnt = arm_len + 1;
                lo_run = 0;
                hi_run = 0;
            end
            if (fl_we_n) hi_run++;
            if (!fl_oe_n) begin
                oe_run++;
                if (fl_dq_oe || p_dqoe) chk(1'b0, "R8 bus driven near OE low", fl_dq_oe, 0);
                if (p_oe) begin
                    rd_cnt++;
                    chk(fl_addr == exp_paddr, "R10/R11 poll address", fl_addr, exp_paddr);
                end
            end else if (!p_oe) begin
                chk(oe_run == N_ACC, "R9 OE low length", oe_run, N_ACC);
                oe_run = 0;
            end
            if (done) begin done_cnt++; done_cyc = cyc; end
            if (busy_cnt > 0) busy_cnt--;
            p_we = fl_we_n; p_oe = fl_oe_n; p_dqoe = fl_dq_oe; p_dq = fl_dq_o;
        end
    end

    function automatic logic [16:0] ex_addr(input int op, input int i, input logic [16:0] a);
        if (i == 1 || i == 4) return 17'h02AAA;
        if (op == 1 && i == 3) return a;
        return 17'h05555;
    endfunction

    function automatic logic [7:0] ex_data(input int op, input int i, input logic [7:0] d);
        case (i)
            0: return 8'hAA;
            1: return 8'h55;
            2: return (op == 1) ? 8'hA0 : 8'h80;
            3: return (op == 1) ? d : 8'hAA;
            4: return 8'h55;
            default: return (op == 3) ? 8'h40 : 8'h10;
        endcase
    endfunction

    int req_cyc = 0;

    task automatic start_op(input int op, input logic [16:0] a, input logic [7:0] d, input int blen);
        wr_cnt = 0; rd_cnt = 0; done_cnt = 0;
        exp_n = (op == 0) ? 0 : ((op == 1) ? 4 : 6);
        arm_len = blen;
        exp_paddr = (op == 2) ? 17'h0 : a;
        fin_valid = (op == 1 || op == 2);
        fin_addr = (op == 2) ? 17'h0 : a;
        fin_data = (op == 2) ? 8'hFF : d;
        @(negedge clk);
        req = 1'b1; req_op = op[1:0]; req_addr = a; req_data = d;
        @(negedge clk);
        req_cyc = cyc;
        req = 1'b0;
        chk(busy == 1'b1, "R13 busy after accept", busy, 1);
    endtask

    task automatic finish_op(input int op, input logic [16:0] a, input logic [7:0] d, input bit exp_err);
        int n;
        n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        chk(done == 1'b1, "R13 done arrives", done, 1);
        chk(err == exp_err, exp_err ? "R12 timeout flag" : "R10/R11 no error", err, exp_err);
        chk(busy == 1'b0, "R13 busy low with done", busy, 0);
        chk(wr_cnt == exp_n, "R2/R5/R6 write count", wr_cnt, exp_n);
        for (int i = 0; i < exp_n && i < 8; i++) begin
            chk(wa[i] == ex_addr(op, i, a), (op == 1) ? "R5 seq address" : "R6 seq address",
                wa[i], ex_addr(op, i, a));
            chk(wd[i] == ex_data(op, i, d), (op == 1) ? "R5 seq data" : "R6 seq data",
                wd[i], ex_data(op, i, d));
        end
        @(negedge clk);
        chk(done == 1'b0, "R13 done one cycle", done, 0);
        chk(done_cnt == 1, "R2 single done", done_cnt, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk({fl_ce_n, fl_we_n, fl_oe_n} == 3'b111, "R1 strobes idle", {fl_ce_n, fl_we_n, fl_oe_n}, 7);
        chk(!fl_dq_oe && !busy && !done, "R1 drive/busy/done low", {fl_dq_oe, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reads over an address sweep
        for (int i = 0; i < 6; i++) begin
            logic [16:0] a;
            a = 17'(i * 17'h05A3B + 17'h00107);
            start_op(0, a, 8'h00, 0);
            finish_op(0, a, 8'h00, 1'b0);
            chk(rdata == pat(a), "R9 read data", rdata, pat(a));
            chk(done_cyc - req_cyc == N_ACC + 1, "R9 read latency", done_cyc - req_cyc, N_ACC + 1);
            chk(rd_cnt == 1, "R9 single read", rd_cnt, 1);
        end

        // R5 R10: program with data patterns that exercise both bit-7 values
        for (int i = 0; i < 7; i++) begin
            logic [7:0]  d;
            logic [16:0] a;
            case (i)
                0: d = 8'h00; 1: d = 8'hFF; 2: d = 8'h5A; 3: d = 8'hA5;
                4: d = 8'h80; 5: d = 8'h7F; default: d = 8'h01;
            endcase
            a = 17'(17'h12345 + i * 17'h01111);
            start_op(1, a, d, 60);
            finish_op(1, a, d, 1'b0);
            chk(rdata == d, "R10 polled byte", rdata, d);
            chk(rd_cnt >= 2, "R10 polled while busy", rd_cnt, 2);
        end

        // R2: request during a program is dropped
        start_op(1, 17'h1F00F, 8'h3C, 60);
        repeat (30) @(negedge clk);
        req = 1'b1; req_op = 2'd2; req_addr = 17'h00AAA; req_data = 8'hEE;
        @(negedge clk);
        req = 1'b0;
        finish_op(1, 17'h1F00F, 8'h3C, 1'b0);
        chk(rdata == 8'h3C, "R2 op unchanged by late request", rdata, 8'h3C);

        // R12: program timeout
        start_op(1, 17'h00042, 8'h99, 600);
        finish_op(1, 17'h00042, 8'h99, 1'b1);
        chk(done_cyc - rise_cyc >= PTMO, "R12 program timeout latency", done_cyc - rise_cyc, PTMO);
        wait (busy_cnt == 0);

        // R6 R11: erase completes
        start_op(2, 17'h0, 8'h00, 100);
        finish_op(2, 17'h0, 8'h00, 1'b0);
        chk(rdata[7] == 1'b1, "R11 erased bit 7", rdata[7], 1);

        // R12: erase timeout
        start_op(2, 17'h0, 8'h00, 1000);
        finish_op(2, 17'h0, 8'h00, 1'b1);
        chk(done_cyc - rise_cyc >= ETMO, "R12 erase timeout latency", done_cyc - rise_cyc, ETMO);
        wait (busy_cnt == 0);
        fin_valid = 1'b0;

        // R7: boot lock, fixed pause and no reads
        start_op(3, 17'h0, 8'h00, 0);
        finish_op(3, 17'h0, 8'h00, 1'b0);
        chk(rd_cnt == 0, "R7 no reads", rd_cnt, 0);
        chk(done_cyc - rise_cyc == N_HI + LWAIT, "R7 pause length", done_cyc - rise_cyc, N_HI + LWAIT);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule